// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block connects a synchronous single-beat request port to an asynchronous static RAM with 19 address bits and 8 data bits. A user raises `req` with an address, a write flag and write data. The request is taken on a clock edge where `ready` is high. The controller then runs one complete memory cycle on active-low chip-enable, write-enable and output-enable strobes. The bidirectional data bus is split into an output value, an input value and a driver-enable.

Each timing window is a whole number of clock cycles. The count is the nanosecond figure of the selected speed grade divided by the clock period and rounded up. Reads keep CE and OE low for the access time. The read byte is captured on the edge where that time runs out, and `rvalid` pulses for one cycle. Writes are WE-controlled and keep OE high. The data drivers stay off until the memory's outputs have had time to float. They stay on long enough to meet data setup, and they are released on the same edge that ends the write. Write-cycle recovery follows the write, and one idle turnaround cycle follows every read.

Top module: `asram_ctl`

## Requirements
- R1: While reset is low at a clock edge, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_en` is 0, `rvalid` is 0, and afterwards `ready` is 1.
- R2: `ready` is high only while the controller is idle, and all three strobes are then high. A request is taken only on an edge where both `req` and `ready` are high, and `ready` is low in the following cycle.
- R3: On the edge that takes a read, `mem_ce_n` and `mem_oe_n` fall and the address is applied, while `mem_we_n` stays 1. Both strobes stay low for ACC cycles. ACC is the largest of the address, chip-enable, output-enable and read-cycle times, each in cycles. At 5 ns on the fast grade ACC = 11.
- R4: On the last edge of the ACC window, `rdata` takes `mem_dq_i`, `mem_ce_n` and `mem_oe_n` rise, and `rvalid` is 1 for exactly one cycle.
- R5: After each read, `ready` stays low for one more turnaround cycle, with all strobes high, before the next request can be taken.
- R6: On the edge that takes a write, `mem_ce_n` and `mem_we_n` fall and the address is applied. `mem_oe_n` stays 1 throughout the write.
- R7: For the first FLT cycles of a write, `mem_dq_en` stays 0. FLT is the WE-to-float time in cycles, which is 4 at 5 ns on the fast grade.
- R8: After the FLT cycles, `mem_dq_en` is 1 for DS cycles with `mem_dq_o` equal to the request's write data. DS is the larger of the data setup time and the remainder of the WE pulse and address-to-end times, which is 6 here. The edge that ends this window raises `mem_we_n` and `mem_ce_n` and clears `mem_dq_en`.
- R9: After WE rises, `ready` stays low for REC cycles. REC = max(1, write cycle time minus FLT minus DS), which is 1 here.
- R10: While `mem_ce_n` is low, `mem_addr` does not change and the driven write data does not change, even if the request inputs change. `mem_dq_en` is never 1 while `mem_oe_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Request address |
| req_wdata | input | 8 | Write data |
| ready | output | 1 | Idle and able to take a request |
| rdata | output | 8 | Captured read byte |
| rvalid | output | 1 | One-cycle pulse: rdata is new |
| mem_addr | output | 19 | Memory address bus |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_o | output | 8 | Data bus value driven on writes |
| mem_dq_i | input | 8 | Data bus value seen from the memory |
| mem_dq_en | output | 1 | Data bus driver enable |

## Verification
A phase counter that has slipped or been loaded with the wrong value moves a strobe edge. That shows up on `mem_ce_n`, `mem_we_n`, `mem_oe_n` or `mem_dq_en` in the very cycle it happens. A read window that is too short captures the placeholder byte the bench memory returns before access time. That wrong byte appears on `rdata` in the `rvalid` cycle. A write with too short a data window is flagged at the WE rising edge. A wrong latch of address or data makes a later read-back disagree with the value written.

// File: rtl/asram_ctl_pkg.sv
// Package: shared state encoding and the timing arithmetic for the
// asynchronous SRAM controller. Assumes nanosecond figures are integers.
package asram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_TURN,
        ST_WFLOAT,
        ST_WDRIVE,
        ST_WREC
    } ctl_state_e;

    typedef enum int {
        TM_RC, TM_AA, TM_ACE, TM_DOE, TM_WC,
        TM_SCE, TM_AW, TM_PWE, TM_SD, TM_HZWE
    } tm_sel_e;

    // Nanosecond figure for one interval of the fast (1) or slow (0) grade.
    function automatic int tm_ns(input bit fast, input tm_sel_e sel);
        case (sel)
            TM_RC, TM_AA, TM_ACE, TM_WC: return fast ? 55 : 70;
            TM_DOE:                      return fast ? 25 : 35;
            TM_SCE, TM_AW:               return fast ? 45 : 60;
            TM_PWE:                      return fast ? 45 : 50;
            TM_SD:                       return 30;
            TM_HZWE:                     return fast ? 20 : 25;
            default:                     return 0;
        endcase
    endfunction

    // Round a nanosecond interval up to whole clock cycles.
    function automatic int ns2cyc(input int ns, input int clk_ps);
        return (ns * 1000 + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_ctl_seq.sv
// Sequencer: holds the controller phase and a single down-counter that
// times every phase. A phase lasts (its count) cycles and ends on the edge
// where the counter reads zero. Assumes every count is at least 1.
module asram_ctl_seq
    import asram_ctl_pkg::*;
#(
    parameter int ACC_C  = 11,
    parameter int FLT_C  = 4,
    parameter int DS_C   = 6,
    parameter int REC_C  = 1,
    parameter int TURN_C = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accept,
    input  logic       is_write,
    output ctl_state_e state,
    output logic       done
);
    localparam int MAXC = imax(imax(ACC_C, FLT_C), imax(imax(DS_C, REC_C), TURN_C));
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] ACC_L  = CW'(ACC_C - 1);
    localparam logic [CW-1:0] FLT_L  = CW'(FLT_C - 1);
    localparam logic [CW-1:0] DS_L   = CW'(DS_C - 1);
    localparam logic [CW-1:0] REC_L  = CW'(REC_C - 1);
    localparam logic [CW-1:0] TURN_L = CW'(TURN_C - 1);

    logic [CW-1:0] cnt;

    assign done = (cnt == '0);

    // Phase register and interval counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    state <= is_write ? ST_WFLOAT : ST_RD;
                    cnt   <= is_write ? FLT_L : ACC_L;
                end
                ST_RD: if (done) begin
                    state <= ST_TURN;
                    cnt   <= TURN_L;
                end else cnt <= cnt - CW'(1);
                ST_WFLOAT: if (done) begin
                    state <= ST_WDRIVE;
                    cnt   <= DS_L;
                end else cnt <= cnt - CW'(1);
                ST_WDRIVE: if (done) begin
                    state <= ST_WREC;
                    cnt   <= REC_L;
                end else cnt <= cnt - CW'(1);
                ST_TURN, ST_WREC: if (done) state <= ST_IDLE;
                                  else cnt <= cnt - CW'(1);
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2
    leave_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && accept) |=> (state != ST_IDLE));
endmodule

// File: rtl/asram_ctl_pins.sv
// Pin stage: every memory-facing signal is a flop so the strobes are
// glitch-free. Reacts to the accept pulse and to the sequencer's phase and
// end-of-phase flag. Assumes the sequencer ends each phase with done high.
module asram_ctl_pins
    import asram_ctl_pkg::*;
#(
    parameter int AW = 19,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          is_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  ctl_state_e    state,
    input  logic          done,
    input  logic [DW-1:0] mem_dq_i,
    output logic [AW-1:0] mem_addr,
    output logic          mem_ce_n,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic [DW-1:0] mem_dq_o,
    output logic          mem_dq_en,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);
    // Address and write data latch, loaded only when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            mem_dq_o <= '0;
        end else if (accept) begin
            mem_addr <= req_addr;
            mem_dq_o <= req_wdata;
        end
    end

    // Strobes, data driver enable and read capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_ce_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_dq_en <= 1'b0;
            rdata     <= '0;
            rvalid    <= 1'b0;
        end else begin
            rvalid <= 1'b0;
            if (accept) begin
                mem_ce_n <= 1'b0;
                mem_we_n <= ~is_write;
                mem_oe_n <= is_write;
            end
            case (state)
                ST_RD: if (done) begin
                    rdata    <= mem_dq_i;
                    rvalid   <= 1'b1;
                    mem_ce_n <= 1'b1;
                    mem_oe_n <= 1'b1;
                end
                ST_WFLOAT: if (done) mem_dq_en <= 1'b1;
                ST_WDRIVE: if (done) begin
                    mem_we_n  <= 1'b1;
                    mem_ce_n  <= 1'b1;
                    mem_dq_en <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // R6
    oe_off_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !mem_we_n) |-> mem_oe_n);
    // R10
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_en |-> mem_oe_n);
    // R7
    drive_after_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_en) |-> (!mem_we_n && $past(!mem_we_n)));
    // R8
    release_with_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (!mem_dq_en && mem_ce_n));
    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_dq_o)));
    // R4
    rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);
endmodule

// File: rtl/asram_ctl.sv
// Asynchronous SRAM controller top. Turns single-beat requests into timed
// read and WE-controlled write cycles. Timing counts are derived from the
// clock period (CLK_PS) and the speed grade (FAST_GRADE). Assumes the
// memory drives mem_dq_i only while CE and OE are low and WE is high.
module asram_ctl
    import asram_ctl_pkg::*;
#(
    parameter int AW         = 19,
    parameter int DW         = 8,
    parameter int CLK_PS     = 5000,
    parameter bit FAST_GRADE = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          ready,
    output logic [DW-1:0] rdata,
    output logic          rvalid,
    output logic [AW-1:0] mem_addr,
    output logic          mem_ce_n,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic [DW-1:0] mem_dq_o,
    input  logic [DW-1:0] mem_dq_i,
    output logic          mem_dq_en
);
    localparam int ACC_C = imax(
        imax(ns2cyc(tm_ns(FAST_GRADE, TM_AA), CLK_PS), ns2cyc(tm_ns(FAST_GRADE, TM_ACE), CLK_PS)),
        imax(ns2cyc(tm_ns(FAST_GRADE, TM_DOE), CLK_PS), ns2cyc(tm_ns(FAST_GRADE, TM_RC), CLK_PS)));
    localparam int FLT_C = imax(1, ns2cyc(tm_ns(FAST_GRADE, TM_HZWE), CLK_PS));
    localparam int END_C = imax(
        imax(ns2cyc(tm_ns(FAST_GRADE, TM_PWE), CLK_PS), ns2cyc(tm_ns(FAST_GRADE, TM_AW), CLK_PS)),
        ns2cyc(tm_ns(FAST_GRADE, TM_SCE), CLK_PS));
    localparam int DS_C  = imax(imax(1, ns2cyc(tm_ns(FAST_GRADE, TM_SD), CLK_PS)), END_C - FLT_C);
    localparam int REC_C = imax(1, ns2cyc(tm_ns(FAST_GRADE, TM_WC), CLK_PS) - FLT_C - DS_C);
    localparam int TURN_C = 1;

    ctl_state_e state;
    logic       done;
    logic       accept;

    assign ready  = (state == ST_IDLE);
    assign accept = req && ready;

    asram_ctl_seq #(
        .ACC_C (ACC_C),
        .FLT_C (FLT_C),
        .DS_C  (DS_C),
        .REC_C (REC_C),
        .TURN_C(TURN_C)
    ) seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .is_write(req_write),
        .state   (state),
        .done    (done)
    );

    asram_ctl_pins #(
        .AW(AW),
        .DW(DW)
    ) pins_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .is_write (req_write),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .state    (state),
        .done     (done),
        .mem_dq_i (mem_dq_i),
        .mem_addr (mem_addr),
        .mem_ce_n (mem_ce_n),
        .mem_we_n (mem_we_n),
        .mem_oe_n (mem_oe_n),
        .mem_dq_o (mem_dq_o),
        .mem_dq_en(mem_dq_en),
        .rdata    (rdata),
        .rvalid   (rvalid)
    );

    // R2
    req_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ready) |=> !ready);
    // R2
    idle_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_en));
endmodule

// File: tb/asram_ctl_tb.sv
`timescale 1ns/1ps
// Bench: a per-cycle behavioural reference of the strobe schedule plus a
// behavioural memory that withholds valid read data until access time.
module asram_ctl_tb_top;
    // Cycle counts at 5 ns, fast grade: 55/5, 20/5, max(30/5, 45/5-4), 1
    localparam int B_ACC = 11;
    localparam int B_FLT = 4;
    localparam int B_DS  = 6;
    localparam int B_REC = 1;
    localparam int B_WTOT = B_FLT + B_DS + B_REC;
    localparam int B_RTOT = B_ACC + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        ready, rvalid, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_en;
    logic [7:0]  rdata, mem_dq_o;
    logic [7:0]  mem_dq_i = 8'hEE;
    logic [18:0] mem_addr;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    asram_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready),
        .rdata(rdata), .rvalid(rvalid), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_o(mem_dq_o), .mem_dq_i(mem_dq_i), .mem_dq_en(mem_dq_en)
    );

    task automatic check(input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // reference model state
    bit          m_busy = 0;
    bit          m_wr = 0;
    int          m_t = 0;
    logic [18:0] m_addr = '0;
    logic [7:0]  m_data = '0;
    logic [7:0]  exp_mem [int];
    // behavioural memory state
    logic [7:0]  sim_mem [int];
    int          rd_cnt = 0;
    int          drv_cnt = 0;
    bit          in_wr = 0;
    logic [18:0] wr_addr = '0;
    logic [7:0]  pend = '0;

    always @(negedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_t = 0;
        end else begin
            bit e_ce_n, e_we_n, e_oe_n, e_en, e_rv;
            string tg;
            e_ce_n = !(m_busy && (m_wr ? (m_t <= B_FLT + B_DS) : (m_t <= B_ACC)));
            e_we_n = !(m_busy && m_wr && m_t <= B_FLT + B_DS);
            e_oe_n = !(m_busy && !m_wr && m_t <= B_ACC);
            e_en   = m_busy && m_wr && m_t > B_FLT && m_t <= B_FLT + B_DS;
            e_rv   = m_busy && !m_wr && m_t == B_ACC + 1;
            if (!m_busy) tg = "R2";
            else if (m_wr) tg = (m_t > B_FLT + B_DS) ? "R9" : "R6";
            else tg = (m_t > B_ACC) ? "R5" : "R3";
            check(tg, "ready", ready, !m_busy);
            check(tg, "ce_n", mem_ce_n, e_ce_n);
            check(tg, "we_n", mem_we_n, e_we_n);
            check(e_rv ? "R4" : tg, "oe_n", mem_oe_n, e_oe_n);
            check((m_t <= B_FLT) ? "R7" : "R8", "dq_en", mem_dq_en, e_en);
            check("R4", "rvalid", rvalid, e_rv);
            if (e_rv)
                check("R4", "rdata", rdata, exp_mem.exists(m_addr) ? exp_mem[m_addr] : 8'h00);
            if (!e_ce_n) check("R10", "addr", mem_addr, m_addr);
            if (e_en) check("R8", "dq_o", mem_dq_o, m_data);
            // advance the model to the next cycle
            if (!m_busy) begin
                if (req) begin
                    m_busy = 1; m_wr = req_write; m_t = 1;
                    m_addr = req_addr; m_data = req_wdata;
                    if (req_write) exp_mem[req_addr] = req_wdata;
                end
            end else begin
                m_t++;
                if (m_t > (m_wr ? B_WTOT : B_RTOT)) begin m_busy = 0; m_t = 0; end
            end
        end
        // memory: valid read data only after full access time
        if (!mem_ce_n && !mem_oe_n && mem_we_n) rd_cnt++; else rd_cnt = 0;
        mem_dq_i = (rd_cnt >= B_ACC) ?
                   (sim_mem.exists(mem_addr) ? sim_mem[mem_addr] : 8'h00) : 8'hEE;
        // memory: write ends when WE or CE rises; data setup is checked then
        if (!mem_ce_n && !mem_we_n) begin
            in_wr = 1; wr_addr = mem_addr;
            if (mem_dq_en) begin drv_cnt++; pend = mem_dq_o; end
        end else if (in_wr) begin
            sim_mem[wr_addr] = pend;
            if (rst_n) check("R8", "data setup cycles>=6", (drv_cnt >= 6), 1);
            in_wr = 0; drv_cnt = 0;
        end
    end

    task automatic do_req(input bit w, input logic [18:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        req = 1; req_write = w; req_addr = a; req_wdata = d;
        @(negedge clk);
        while (!ready) @(negedge clk);
        @(posedge clk); #1;
        req = 0; req_addr = ~a; req_wdata = ~d;   // R10: scrambled inputs ignored
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!ready) @(negedge clk);
    endtask

    task automatic check_reset();
        @(negedge clk);
        check("R1", "ce_n", mem_ce_n, 1);
        check("R1", "we_n", mem_we_n, 1);
        check("R1", "oe_n", mem_oe_n, 1);
        check("R1", "dq_en", mem_dq_en, 0);
        check("R1", "rvalid", rvalid, 0);
        check("R1", "ready", ready, 1);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        check_reset();
        @(posedge clk); #1 rst_n = 1;
        // writes to low, high and middle addresses
        do_req(1, 19'h00000, 8'h3C);
        do_req(1, 19'h7FFFF, 8'hC3);
        do_req(1, 19'h12345, 8'h5A);
        // reads back to back
        do_req(0, 19'h7FFFF, 8'h00);
        do_req(0, 19'h00000, 8'h00);
        do_req(0, 19'h12345, 8'h00);
        // read then write (turnaround), then read back
        do_req(0, 19'h12345, 8'h00);
        do_req(1, 19'h12345, 8'h99);
        do_req(0, 19'h12345, 8'h00);
        // address never written
        do_req(0, 19'h40000, 8'h00);
        // reset in the middle of a write
        do_req(1, 19'h01111, 8'h77);
        repeat (3) @(posedge clk);
        #1 rst_n = 0;
        repeat (2) @(posedge clk);
        check_reset();
        @(posedge clk); #1 rst_n = 1;
        // recovery after reset
        do_req(1, 19'h2AAAA, 8'hA5);
        do_req(0, 19'h2AAAA, 8'h00);
        wait_idle();
        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule